// File: doc/BRIEF.md
# Edge/Level Interrupt Request Latch

This block captures interrupt requests from a set of input lines into a pending-request register. Each line has its own trigger-mode bit. When the bit is set, the line is level-sensitive: its pending bit follows the input. When the bit is clear, the line is edge-sensitive: a rising input latches a request, and the request stays until something clears it. The block samples every line on every clock and keeps the previous sample so that it can find rising edges.

A fixed instance parameter says which lines may ever be made level-sensitive. A mode write silently drops any bit outside that set. The primary controller uses `8'hF8` and the secondary uses `8'hDE`.

Two clear inputs are provided. The acknowledge port clears the indexed request, but only if that line is edge-sensitive. The direct clear port removes the indexed request whatever the line's mode. On every cycle the block also reports, for each line raising a request, one of three outcomes: masked, newly latched, or merged into a request that was already pending.

Top module: `irq_capture_latch`

## Requirements
- R1: A synchronous reset clears the pending register, the stored previous levels and the trigger-mode register. As a result, a line held high through reset counts as a rising edge on the first sampled cycle after reset.
- R2: A line whose mode bit is 1 (level) has its pending bit equal to the input sampled at the previous clock edge. The bit is set while the input is high and cleared once it is low.
- R3: A line whose mode bit is 0 (edge) gets its pending bit set only when the input is high and the previously sampled level was low.
- R4: On an edge-mode line, a low input does not clear a pending bit. Only the acknowledge port or the clear port removes it.
- R5: A mode write stores the write data ANDed with the instance parameter `LEVEL_OK`. The `mode` output shows the result from the next cycle. Bit i = 1 selects level mode for line i.
- R6: An acknowledge for index i clears pending bit i only when line i is in edge mode. It has no effect on a level-mode line whose input is still high.
- R7: The clear port clears pending bit i in either mode. If the same line raises a request in that cycle, the request wins and the bit stays set.
- R8: A line raises a request in a cycle when it is in level mode and its input is high, or in edge mode and it shows a rising edge. For such a line, exactly one status bit is high:
  - `hit_masked` when its `mask_in` bit is 1;
  - otherwise `hit_new` when its pending bit is currently 0;
  - otherwise `hit_coal`.
  
  A line that raises no request reports no status. The mask does not prevent latching.
- R9: Changing a line's mode does not touch its stored previous level. A line held high while it is switched from level to edge mode raises no new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_in | input | LINES | Request input levels |
| mask_in | input | LINES | Per-line mask used only for status reporting |
| mode_we | input | 1 | Trigger-mode write strobe |
| mode_wdata | input | LINES | Trigger-mode write data (1 = level) |
| ack_en | input | 1 | Acknowledge strobe |
| ack_idx | input | IW | Line index being acknowledged |
| clr_en | input | 1 | Direct clear strobe |
| clr_idx | input | IW | Line index to clear |
| pending | output | LINES | Pending-request register |
| mode | output | LINES | Trigger-mode register |
| hit_masked | output | LINES | Request raised on a masked line this cycle |
| hit_new | output | LINES | Request raised on an unmasked line that was not pending |
| hit_coal | output | LINES | Request raised on an unmasked line that was already pending |

## Verification
The stored previous levels can only be seen through their effect. If one of them is wrong, an edge-mode line either latches a request that it should not, or misses a rising edge. The status outputs show this in the same cycle, and `pending` shows it one clock later. Errors in the pending register or the mode register appear on `pending` and `mode` at the next clock edge. A wrong pending bit also flips the status of the next request on that line between new and merged. For this reason the bench compares every output against a behavioural model on every cycle. It does this for two instances that differ only in their writable-mode parameter.

// File: rtl/irq_capture_latch.sv
module irq_capture_latch #(
  parameter int LINES = 8,
  parameter logic [LINES-1:0] LEVEL_OK = 8'hF8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [LINES-1:0]           req_in,
  input  logic [LINES-1:0]           mask_in,
  input  logic                       mode_we,
  input  logic [LINES-1:0]           mode_wdata,
  input  logic                       ack_en,
  input  logic [$clog2(LINES)-1:0]   ack_idx,
  input  logic                       clr_en,
  input  logic [$clog2(LINES)-1:0]   clr_idx,
  output logic [LINES-1:0]           pending,
  output logic [LINES-1:0]           mode,
  output logic [LINES-1:0]           hit_masked,
  output logic [LINES-1:0]           hit_new,
  output logic [LINES-1:0]           hit_coal
);
  localparam int IW = $clog2(LINES);

  logic [LINES-1:0] pend_q, last_q, mode_q;
  logic [LINES-1:0] raise, ack_hit, clr_hit, keep, pend_d;

  assign raise   = (mode_q & req_in) | (~mode_q & req_in & ~last_q);
  assign ack_hit = ack_en ? ((LINES'(1) << ack_idx) & ~mode_q) : '0;
  assign clr_hit = clr_en ? (LINES'(1) << clr_idx) : '0;
  assign keep    = pend_q & ~ack_hit & ~clr_hit;
  assign pend_d  = (mode_q & req_in) | (~mode_q & (keep | raise));

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      last_q <= '0;
      mode_q <= '0;
    end else begin
      pend_q <= pend_d;
      last_q <= req_in;
      if (mode_we) mode_q <= mode_wdata & LEVEL_OK;
    end
  end

  assign pending    = pend_q;
  assign mode       = mode_q;
  assign hit_masked = raise & mask_in;
  assign hit_new    = raise & ~mask_in & ~pend_q;
  assign hit_coal   = raise & ~mask_in & pend_q;

  p_mode_mask_r5: assert property (@(posedge clk) disable iff (rst)
    mode_we |=> mode_q == ($past(mode_wdata) & LEVEL_OK));

  for (genvar i = 0; i < LINES; i++) begin : g_chk
    p_level_follow_r2: assert property (@(posedge clk) disable iff (rst)
      mode_q[i] |=> pend_q[i] == $past(req_in[i]));

    p_edge_only_rise_r3: assert property (@(posedge clk) disable iff (rst)
      (!mode_q[i] && !pend_q[i] && !(req_in[i] && !last_q[i])) |=> !pend_q[i]);

    p_edge_hold_r4: assert property (@(posedge clk) disable iff (rst)
      (!mode_q[i] && pend_q[i] && !(ack_en && ack_idx == IW'(i))
        && !(clr_en && clr_idx == IW'(i))) |=> pend_q[i]);

    p_ack_level_r6: assert property (@(posedge clk) disable iff (rst)
      (mode_q[i] && req_in[i] && ack_en && ack_idx == IW'(i)) |=> pend_q[i]);

    p_new_latches_r8: assert property (@(posedge clk) disable iff (rst)
      hit_new[i] |=> pend_q[i]);
  end
endmodule

// File: tb/irq_capture_latch_test.sv
module irq_capture_latch_test;
  localparam int CLK_P = 10;

  logic clk = 0;
  always #(CLK_P/2) clk = ~clk;

  logic       rst = 1;
  logic [7:0] req = 0, msk = 0, wd = 0;
  logic       we = 0, ae = 0, ce = 0;
  logic [2:0] ai = 0, ci = 0;

  logic [7:0] pend0, mode0, hm0, hn0, hc0;
  logic [7:0] pend1, mode1, hm1, hn1, hc1;

  irq_capture_latch #(.LINES(8), .LEVEL_OK(8'hF8)) uut (
    .clk(clk), .rst(rst), .req_in(req), .mask_in(msk), .mode_we(we),
    .mode_wdata(wd), .ack_en(ae), .ack_idx(ai), .clr_en(ce), .clr_idx(ci),
    .pending(pend0), .mode(mode0), .hit_masked(hm0), .hit_new(hn0), .hit_coal(hc0));

  irq_capture_latch #(.LINES(8), .LEVEL_OK(8'hDE)) uut2 (
    .clk(clk), .rst(rst), .req_in(req), .mask_in(msk), .mode_we(we),
    .mode_wdata(wd), .ack_en(ae), .ack_idx(ai), .clr_en(ce), .clr_idx(ci),
    .pending(pend1), .mode(mode1), .hit_masked(hm1), .hit_new(hn1), .hit_coal(hc1));

  int checks = 0, errors = 0;
  logic [7:0] m_pend [2], m_last [2], m_mode [2];

  task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic cycle(input string tag);
    logic [7:0] em [2], en [2], ec [2], np [2], nl [2], nm [2];
    for (int k = 0; k < 2; k++) begin
      logic [7:0] wr;
      wr = (k == 0) ? 8'hF8 : 8'hDE;
      for (int i = 0; i < 8; i++) begin
        logic lvl, inb, evt, p;
        lvl = m_mode[k][i];
        inb = req[i];
        evt = lvl ? inb : (inb && !m_last[k][i]);
        em[k][i] = evt && msk[i];
        en[k][i] = evt && !msk[i] && !m_pend[k][i];
        ec[k][i] = evt && !msk[i] && m_pend[k][i];
        if (lvl) p = inb;
        else begin
          p = m_pend[k][i];
          if (ae && ai == 3'(i)) p = 1'b0;
          if (ce && ci == 3'(i)) p = 1'b0;
          if (evt) p = 1'b1;
        end
        np[k][i] = p;
      end
      nl[k] = req;
      nm[k] = we ? (wd & wr) : m_mode[k];
      if (rst) begin np[k] = 0; nl[k] = 0; nm[k] = 0; end
    end
    #1;
    if (!rst) begin
      chk(tag, "masked0", hm0, em[0]); chk(tag, "new0", hn0, en[0]); chk(tag, "coal0", hc0, ec[0]);
      chk(tag, "masked1", hm1, em[1]); chk(tag, "new1", hn1, en[1]); chk(tag, "coal1", hc1, ec[1]);
    end
    @(posedge clk); #1;
    for (int k = 0; k < 2; k++) begin
      m_pend[k] = np[k]; m_last[k] = nl[k]; m_mode[k] = nm[k];
    end
    chk(tag, "pending0", pend0, m_pend[0]); chk(tag, "mode0", mode0, m_mode[0]);
    chk(tag, "pending1", pend1, m_pend[1]); chk(tag, "mode1", mode1, m_mode[1]);
    @(negedge clk);
    we = 0; ae = 0; ce = 0;
  endtask

  task automatic go(input logic [7:0] r, input string tag);
    req = r;
    cycle(tag);
  endtask

  initial begin
    #(CLK_P * 200000);
    checks++; errors++;
    $display("FAIL R1 watchdog act=timeout exp=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < 2; k++) begin m_pend[k] = 0; m_last[k] = 0; m_mode[k] = 0; end
    @(negedge clk);
    rst = 1;
    go(8'hFF, "R1"); go(8'hFF, "R1");
    rst = 0;
    // R1: last levels cleared, so lines held high latch at once
    go(8'hFF, "R1");
    go(8'hFF, "R3");
    go(8'h00, "R4"); go(8'h00, "R4");
    for (int i = 0; i < 8; i++) begin ae = 1; ai = 3'(i); go(8'h00, "R6"); end
    go(8'h55, "R3"); go(8'hAA, "R3"); go(8'h00, "R4");
    for (int i = 0; i < 8; i++) begin ce = 1; ci = 3'(i); go(8'h00, "R7"); end
    we = 1; wd = 8'hFF; go(8'h00, "R5");
    go(8'hFF, "R2"); go(8'h00, "R2"); go(8'hFF, "R2");
    ae = 1; ai = 3'd3; go(8'hFF, "R6");
    ae = 1; ai = 3'd0; go(8'hFF, "R6");
    ce = 1; ci = 3'd3; go(8'hFF, "R7");
    ce = 1; ci = 3'd0; go(8'hFF, "R7");
    go(8'h00, "R7"); ce = 1; ci = 3'd0; go(8'h01, "R7");
    msk = 8'h0F; go(8'hF0, "R8"); go(8'h0F, "R8"); go(8'hFF, "R8");
    msk = 8'h00; go(8'h00, "R8"); go(8'hFF, "R8"); go(8'hFF, "R8");
    we = 1; wd = 8'h00; go(8'hFF, "R9");
    go(8'hFF, "R9");
    for (int i = 0; i < 8; i++) begin ae = 1; ai = 3'(i); go(8'hFF, "R9"); end
    go(8'hFF, "R9");
    we = 1; wd = 8'h5A; go(8'h00, "R5");
    for (int n = 0; n < 400; n++) begin
      msk = 8'($urandom);
      we = ($urandom % 8) == 0; wd = 8'($urandom);
      ae = ($urandom % 3) == 0; ai = 3'($urandom);
      ce = ($urandom % 5) == 0; ci = 3'($urandom);
      go(8'($urandom), "R2 R3 R4 R6 R7 R8");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule